// File: doc/BRIEF.md
# I2S Master Bit-Clock and Frame-Sync Generator

This block produces the two timing clocks of an I2S master link, the bit clock and the frame sync. Both come from one fast codec operating clock. Each output has its own programmable divider and counter, and neither output is derived from the other. The bit-clock divider is an 8-bit value. The frame-sync divider is 16 bits wide and arrives as a high byte and a low byte, which are joined as {high, low}. Each output toggles whenever its counter reaches the programmed limit. This gives a half period of (divider + 1) codec cycles and a 50% duty cycle.

A single active-high gate input switches both outputs off. While the gate is set, both outputs sit low and both counters stay cleared. When the gate is released, the two outputs restart together from a known phase.

A combinational flag reports divider settings that break the required frequency ratios:
- The bit clock must be faster than 34 times the frame rate.
- The codec clock must be at least 6 times the bit clock.

A divider value that changes while the block is running is taken up only when that counter next reloads. As a result, a half period is never cut short.

Top module: `i2s_mclk_gen`

## Requirements
- R1: After the gate is released, `bclk` is low. After k released clock edges, `bclk` equals floor(k / (ck_div + 1)) mod 2, so each half period lasts ck_div + 1 cycles.
- R2: Let the frame divider F be {fs_div_hi, fs_div_lo}, with fs_div_hi in bits 15:8 and fs_div_lo in bits 7:0. After k released edges, `fsync` equals floor(k / (F + 1)) mod 2.
- R3: The two outputs are divided independently from the same clock. Both restart from low on the same release edge, whatever the two divider values are.
- R4: One clock edge after `gate_off` is 1, both `bclk` and `fsync` are 0. The next release then starts again at phase zero.
- R5: `cfg_err` is 1 whenever ck_div + 1 < 3, because the codec clock would then be less than 6 times the bit clock.
- R6: `cfg_err` is 1 whenever F + 1 <= 34 * (ck_div + 1), because the bit clock would then not exceed 34 times the frame rate.
- R7: `cfg_err` is 0 when neither the condition of R5 nor the condition of R6 holds. The flag is purely combinational.
- R8: A divider value that changes while an output runs takes effect only at that output's next reload. The half period in progress keeps its old length.
- R9: While `rst_n` is low, `bclk` and `fsync` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Codec operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_off | input | 1 | 1 stops and holds both outputs low; 0 lets them run |
| ck_div | input | CK_W (8) | Bit-clock divider value |
| fs_div_hi | input | FS_HALF_W (8) | Frame-sync divider, upper byte |
| fs_div_lo | input | FS_HALF_W (8) | Frame-sync divider, lower byte |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync clock |
| cfg_err | output | 1 | Divider ratio violation flag |

## Verification
The bench sweeps every small divider pair and predicts each output cycle by cycle from floor(k / (div + 1)) mod 2. Each of the following design errors would break that prediction:
- A counter that is off by one, which would stretch or shorten every half period.
- A byte order of the two frame bytes that is swapped, which would make the 258-count frame run at 513 instead.
- A restart that does not clear the phase, which would leave a stale high level after release.

Changes to a divider in mid-run are timed against the reload edge. A design that applies a new value at once would produce a clipped half period at that point.

The ratio flag is swept over all 256 bit-clock values. Each value is tried exactly at the 34x boundary and one count past it, so a comparison of < where <= is required flips the flag there. The smallest divider values probe the 6x rule.

// File: rtl/i2s_mclk_gen_pkg.sv
package i2s_mclk_gen_pkg;
    // The bit clock must exceed this multiple of the frame rate
    localparam int unsigned FRAME_RATIO   = 34;
    // The codec clock must be at least this multiple of the bit clock
    localparam int unsigned CODEC_RATIO   = 6;
    // Each output period spans 2*(div+1) codec cycles, so div+1 >= ceil(CODEC_RATIO/2)
    localparam int unsigned MIN_CK_SPAN   = (CODEC_RATIO + 1) / 2;
    // Bits needed to hold FRAME_RATIO
    localparam int unsigned RATIO_BITS    = $clog2(FRAME_RATIO + 1);
endpackage

// File: rtl/i2s_half_div.sv
module i2s_half_div #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit_in,
    output logic         tgl_out
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
        logic         tgl;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.lim = limit_in;
            st_d.tgl = 1'b0;
        end else if (st_q.cnt == st_q.lim) begin
            st_d.cnt = '0;
            st_d.lim = limit_in;
            st_d.tgl = ~st_q.tgl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgl_out = st_q.tgl;

    // R4
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!st_q.tgl && st_q.cnt == '0));

    // R1
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.cnt != st_q.lim) |=> $stable(st_q.tgl));

    // R8
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.cnt != st_q.lim) |=> $stable(st_q.lim));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);
endmodule

// File: rtl/i2s_ratio_chk.sv
module i2s_ratio_chk
    import i2s_mclk_gen_pkg::*;
#(
    parameter int unsigned CK_W = 8,
    parameter int unsigned FS_W = 16
) (
    input  logic [CK_W-1:0] ck_div,
    input  logic [FS_W-1:0] fs_div,
    output logic            ratio_err
);
    localparam int unsigned SPAN_W = CK_W + 1 + RATIO_BITS;
    localparam int unsigned CMP_W  = ((FS_W + 1 > SPAN_W) ? FS_W + 1 : SPAN_W);

    logic [CMP_W-1:0] ck_p1_d, fs_p1_d, span_d;

    always_comb begin
        ck_p1_d   = CMP_W'(ck_div) + CMP_W'(1);
        fs_p1_d   = CMP_W'(fs_div) + CMP_W'(1);
        span_d    = ck_p1_d * CMP_W'(FRAME_RATIO);
        ratio_err = (fs_p1_d <= span_d) || (ck_p1_d < CMP_W'(MIN_CK_SPAN));
    end
endmodule

// File: rtl/i2s_mclk_gen.sv
module i2s_mclk_gen
    import i2s_mclk_gen_pkg::*;
#(
    parameter int unsigned CK_W      = 8,
    parameter int unsigned FS_HALF_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gate_off,
    input  logic [CK_W-1:0]      ck_div,
    input  logic [FS_HALF_W-1:0] fs_div_hi,
    input  logic [FS_HALF_W-1:0] fs_div_lo,
    output logic                 bclk,
    output logic                 fsync,
    output logic                 cfg_err
);
    localparam int unsigned FS_W = 2 * FS_HALF_W;

    logic            run_d;
    logic [FS_W-1:0] fs_div_d;

    always_comb begin
        run_d    = ~gate_off;
        fs_div_d = {fs_div_hi, fs_div_lo};
    end

    i2s_half_div #(.W(CK_W)) u_bclk_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_d),
        .limit_in (ck_div),
        .tgl_out  (bclk)
    );

    i2s_half_div #(.W(FS_W)) u_fsync_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_d),
        .limit_in (fs_div_d),
        .tgl_out  (fsync)
    );

    i2s_ratio_chk #(.CK_W(CK_W), .FS_W(FS_W)) u_ratio (
        .ck_div    (ck_div),
        .fs_div    (fs_div_d),
        .ratio_err (cfg_err)
    );

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |=> (!bclk && !fsync));

    // R5
    codec_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CK_W'(ck_div) < CK_W'(MIN_CK_SPAN - 1)) |-> cfg_err);

    // R3
    joint_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_off) |-> (!bclk && !fsync));
endmodule

// File: tb/tb_i2s_mclk_gen.sv
module tb_i2s_mclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_off = 1'b1;
    logic [7:0] ck_div = '0;
    logic [7:0] fs_div_hi = '0;
    logic [7:0] fs_div_lo = '0;
    logic       bclk, fsync, cfg_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    i2s_mclk_gen dut (
        .clk(clk), .rst_n(rst_n), .gate_off(gate_off), .ck_div(ck_div),
        .fs_div_hi(fs_div_hi), .fs_div_lo(fs_div_lo),
        .bclk(bclk), .fsync(fsync), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int err_model(input int ck, input int fs);
        return ((fs + 1) <= 34 * (ck + 1)) || ((ck + 1) < 3);
    endfunction

    // Stop, load dividers, release, then compare n cycles (R1 R2 R3 R4)
    task automatic run_cfg(input int ck, input int fs, input int n);
        @(negedge clk);
        gate_off  = 1'b1;
        ck_div    = 8'(ck);
        fs_div_hi = 8'(fs >> 8);
        fs_div_lo = 8'(fs);
        @(posedge clk); #1;
        check("R4 bclk off", int'(bclk), 0);
        check("R4 fsync off", int'(fsync), 0);
        @(negedge clk);
        gate_off = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk); #1;
            check("R1 bclk", int'(bclk), (k / (ck + 1)) % 2);
            check("R2 fsync", int'(fsync), (k / (fs + 1)) % 2);
        end
    endtask

    // Change the bit divider from a to b after c released edges (R8)
    task automatic run_change(input int a, input int b, input int c, input int n);
        int e0;
        int exp;
        run_cfg(a, 40, c);
        e0 = (c / (a + 1) + 1) * (a + 1);
        @(negedge clk);
        ck_div = 8'(b);
        for (int k = c + 1; k <= n; k++) begin
            @(posedge clk); #1;
            if (k <= e0) exp = (k / (a + 1)) % 2;
            else         exp = (e0 / (a + 1) + (k - e0) / (b + 1)) % 2;
            check("R8 reload", int'(bclk), exp);
            if (k < n) @(negedge clk);
        end
    endtask

    initial begin
        int fsv [5] = '{0, 1, 2, 7, 20};
        #1;
        check("R9 bclk reset", int'(bclk), 0);
        check("R9 fsync reset", int'(fsync), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int ck = 0; ck <= 5; ck++)
            for (int j = 0; j < 5; j++)
                run_cfg(ck, fsv[j], 80);
        run_cfg(2, 258, 1100);
        run_cfg(0, 0, 10);

        run_change(5, 1, 8, 40);
        run_change(2, 4, 3, 40);
        run_change(1, 6, 5, 40);

        for (int ck = 0; ck < 256; ck++) begin
            int edge_fs [4];
            edge_fs = '{34 * (ck + 1) - 1, 34 * (ck + 1), 0, 65535};
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                ck_div    = 8'(ck);
                fs_div_hi = 8'(edge_fs[j] >> 8);
                fs_div_lo = 8'(edge_fs[j]);
                #1;
                if (ck < 2)
                    check("R5 codec ratio", int'(cfg_err), err_model(ck, edge_fs[j]));
                else if (err_model(ck, edge_fs[j]) != 0)
                    check("R6 frame ratio", int'(cfg_err), 1);
                else
                    check("R7 legal", int'(cfg_err), 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule